// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the write-side command interpreter of a 16-bit-wide NOR flash model. It observes qualified bus write cycles, each one an address and a data word, and follows the unlock-prefixed command sequences. When a sequence is complete and allowed, it issues a one-cycle request to the embedded program/erase engine. The request carries the operation, the final cycle's address and data, and a mask of the storage regions affected. Only the low data byte takes part in command matching.

The block also holds the boot-region lock. The lock starts cleared at power-up, a command sets it, and the synchronous reset does not clear it. While the lock is set, the block refuses a chip erase and any program that targets the boot region, and it removes the boot region from the erase of the boot/main sector. An override input, which models high-voltage detection, lifts these limits. A product-identification mode switches a small read port to return identity codes and the lock status. Array storage and operation timing are outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: When rst is high at a clock edge, the sequence returns to idle, id_mode becomes 0, req_valid becomes 0 and id_rd_data becomes 0. The reset does not change the value of locked.
- R2: Word program is the write sequence 0x05555/AA, 0x02AAA/55, 0x05555/A0, followed by a fourth write to any address. After the clock edge that captures the fourth write, req_valid is 1 for exactly one cycle, with req_op=0 and with req_addr and req_data equal to that fourth write's full address and full 16-bit data.
- R3: Command matching compares only data bits 7..0. Bits 15..8 of command writes have no effect.
- R4: A write that does not match the step expected next returns the decoder to idle without a request. That write is not reused as the first step of a new sequence.
- R5: Chip erase is 0x05555/AA, 0x02AAA/55, 0x05555/80, 0x05555/AA, 0x02AAA/55, 0x05555/10. It requests req_op=1 with req_regions=4'b1111. The region bits are: bit0 boot (0x00000–0x01FFF), bit1 parameter A (0x02000–0x03FFF), bit2 parameter B (0x04000–0x05FFF), bit3 main (0x06000 and up).
- R6: Sector erase uses the same first five writes as chip erase, then a sixth write of data 30 to a sector address. It requests req_op=2. The sector is chosen by address bits 16..13: value 1 gives req_regions 4'b0010, value 2 gives 4'b0100, and any other value selects the boot/main sector, which gives 4'b1001 while the lock is clear.
- R7: The lock command uses the same first five writes, then a sixth write of 0x05555/40. It sets locked to 1 and issues no request. locked stays 1 across rst.
- R8: While locked=1 and hv_override=0: chip erase issues no request; a program whose address is in 0x00000–0x01FFF issues no request; erase of the boot/main sector gives req_regions 4'b1000. Programs to other addresses proceed normally.
- R9: While hv_override=1, the lock has no effect. Boot programs and chip erase are requested, and erase of the boot/main sector gives 4'b1001.
- R10: Two unlock writes followed by 0x05555/90 set id_mode. Two unlock writes followed by 0x05555/F0, or a single write of data F0 to any address while the decoder is idle, clear id_mode.
- R11: id_rd_data is registered one cycle after rd_addr. In ID mode it returns 0x1F at address 0, 0x82 at address 1, the value of locked in bit 0 at address 2, and 0 elsewhere. Outside ID mode it returns 0.
- R12: While busy=1, writes are ignored. The sequence step and id_mode do not change, and no request results from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Qualified bus write strobe |
| wr_addr | input | 17 | Write word address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Embedded operation in progress |
| hv_override | input | 1 | Boot lock bypass flag |
| rd_addr | input | 17 | ID-mode read address |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 2 | 0 program, 1 chip erase, 2 sector erase |
| req_addr | output | 17 | Address of the final command write |
| req_data | output | 16 | Data of the final command write |
| req_regions | output | 4 | Affected regions mask |
| id_mode | output | 1 | Product-ID mode active |
| locked | output | 1 | Boot lock state |
| id_rd_data | output | 8 | ID-mode read data |

## Verification
Some properties are checked by assertions on every cycle:
- A request never lasts longer than one cycle.
- Every chip erase covers all regions.
- No chip erase, and no boot-region program, is issued while the lock is set without the override.
- The lock never falls once it has risen.
- Busy freezes the sequence state.
- ID read data is zero unless ID mode was active.

Other behaviours depend on complete write scenarios, so only the bench can show them. These are the exact address and data of each request, the region mask chosen for each sector, the refusal of a mismatched or busy-time write, lock retention through reset, and the identity values returned.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA3, S_ERA4, S_ERA5
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2,
    OP_LOCK = 2'd3
  } cmd_op_t;

  localparam int REGION_N = 4;
  localparam int RG_BOOT  = 0;
  localparam int RG_PARA  = 1;
  localparam int RG_PARB  = 2;
  localparam int RG_MAIN  = 3;

  localparam logic [7:0] CODE_KEY1   = 8'hAA;
  localparam logic [7:0] CODE_KEY2   = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_ID_IN  = 8'h90;
  localparam logic [7:0] CODE_ID_OUT = 8'hF0;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECT   = 8'h30;
  localparam logic [7:0] CODE_LOCK   = 8'h40;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] KEY_ADDR1 = 17'h05555,
  parameter logic [ADDR_W-1:0] KEY_ADDR2 = 17'h02AAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        cmd_byte,
  output logic              cmd_go,
  output cmd_op_t           cmd_op,
  output logic              id_mode
);
  seq_state_t state_q, state_d;
  logic id_q, id_set, id_clr;
  logic wv, at1, at2;

  assign wv  = wr_en && !busy;
  assign at1 = (wr_addr == KEY_ADDR1);
  assign at2 = (wr_addr == KEY_ADDR2);

  always_comb begin
    state_d = state_q;
    cmd_go  = 1'b0;
    cmd_op  = OP_PROG;
    id_set  = 1'b0;
    id_clr  = 1'b0;
    if (wv) begin
      state_d = S_IDLE;
      case (state_q)
        S_IDLE: begin
          if (at1 && cmd_byte == CODE_KEY1) state_d = S_UNL1;
          else if (cmd_byte == CODE_ID_OUT) id_clr = 1'b1;
        end
        S_UNL1: if (at2 && cmd_byte == CODE_KEY2) state_d = S_UNL2;
        S_UNL2: if (at1) begin
          case (cmd_byte)
            CODE_PROG:   state_d = S_PROG;
            CODE_ERASE:  state_d = S_ERA3;
            CODE_ID_IN:  id_set  = 1'b1;
            CODE_ID_OUT: id_clr  = 1'b1;
            default:     state_d = S_IDLE;
          endcase
        end
        S_PROG: begin
          cmd_go = 1'b1;
          cmd_op = OP_PROG;
        end
        S_ERA3: if (at1 && cmd_byte == CODE_KEY1) state_d = S_ERA4;
        S_ERA4: if (at2 && cmd_byte == CODE_KEY2) state_d = S_ERA5;
        S_ERA5: begin
          if (at1 && cmd_byte == CODE_CHIP) begin
            cmd_go = 1'b1; cmd_op = OP_CHIP;
          end else if (at1 && cmd_byte == CODE_LOCK) begin
            cmd_go = 1'b1; cmd_op = OP_LOCK;
          end else if (cmd_byte == CODE_SECT) begin
            cmd_go = 1'b1; cmd_op = OP_SECT;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (id_set)      id_q <= 1'b1;
      else if (id_clr) id_q <= 1'b0;
    end
  end

  assign id_mode = id_q;

  // R12: a busy cycle leaves sequence step and ID mode untouched
  a_r12_busy_freezes: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(state_q) && $stable(id_q)));

  // R4: a wrong second unlock write lands in idle
  a_r4_bad_unlock_idle: assert property (@(posedge clk) disable iff (rst)
    (wv && state_q == S_UNL1 && !(at2 && cmd_byte == CODE_KEY2)) |=> (state_q == S_IDLE));
endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int BLK_SHIFT = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_go,
  input  cmd_op_t             cmd_op,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                hv_ovr,
  output logic                req_valid,
  output logic [1:0]          req_op,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [DATA_W-1:0]   req_data,
  output logic [REGION_N-1:0] req_regions,
  output logic                locked
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic lock_q = 1'b0;
  logic [BLK_W-1:0] blk;
  logic boot_open, allow;
  logic [REGION_N-1:0] regions;

  assign blk       = wr_addr[ADDR_W-1:BLK_SHIFT];
  assign boot_open = !lock_q || hv_ovr;

  always_comb begin
    regions = '0;
    allow   = 1'b0;
    case (cmd_op)
      OP_PROG: begin
        if (blk == BLK_W'(0))      regions[RG_BOOT] = 1'b1;
        else if (blk == BLK_W'(1)) regions[RG_PARA] = 1'b1;
        else if (blk == BLK_W'(2)) regions[RG_PARB] = 1'b1;
        else                       regions[RG_MAIN] = 1'b1;
        allow = boot_open || (blk != BLK_W'(0));
      end
      OP_CHIP: begin
        regions = '1;
        allow   = boot_open;
      end
      OP_SECT: begin
        if (blk == BLK_W'(1))      regions[RG_PARA] = 1'b1;
        else if (blk == BLK_W'(2)) regions[RG_PARB] = 1'b1;
        else begin
          regions[RG_MAIN] = 1'b1;
          regions[RG_BOOT] = boot_open;
        end
        allow = 1'b1;
      end
      default: allow = 1'b0;
    endcase
  end

  // the lock survives rst: it is only ever set
  always_ff @(posedge clk) begin
    if (cmd_go && cmd_op == OP_LOCK) lock_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_op      <= 2'd0;
      req_addr    <= '0;
      req_data    <= '0;
      req_regions <= '0;
    end else begin
      req_valid <= cmd_go && allow;
      if (cmd_go && allow) begin
        req_op      <= cmd_op;
        req_addr    <= wr_addr;
        req_data    <= wr_data;
        req_regions <= regions;
      end
    end
  end

  assign locked = lock_q;

  // R2: requests are single-cycle pulses
  a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R5: chip erase covers every region
  a_r5_chip_all_regions: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_CHIP) |-> (req_regions == '1));

  // R8: no chip erase under an active lock
  a_r8_chip_blocked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_CHIP) |-> (!$past(lock_q) || $past(hv_ovr)));

  // R8: no boot program under an active lock
  a_r8_boot_prog_blocked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_PROG && req_addr[ADDR_W-1:BLK_SHIFT] == '0)
      |-> (!$past(lock_q) || $past(hv_ovr)));

  // R7: lock never falls
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom #(
  parameter int ADDR_W = 17,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'h82
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic              locked,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_rd_data
);
  always_ff @(posedge clk) begin
    if (rst || !id_mode) id_rd_data <= 8'h00;
    else begin
      case (rd_addr)
        ADDR_W'(0): id_rd_data <= MFR_CODE;
        ADDR_W'(1): id_rd_data <= DEV_CODE;
        ADDR_W'(2): id_rd_data <= {7'b0, locked};
        default:    id_rd_data <= 8'h00;
      endcase
    end
  end

  // R11: nonzero ID data only follows a cycle in ID mode
  a_r11_quiet_outside_id: assert property (@(posedge clk) disable iff (rst)
    (id_rd_data != 8'h00) |-> $past(id_mode));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int BLK_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              hv_override,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [3:0]        req_regions,
  output logic              id_mode,
  output logic              locked,
  output logic [7:0]        id_rd_data
);
  logic    cmd_go;
  cmd_op_t cmd_op;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy),
    .wr_addr(wr_addr), .cmd_byte(wr_data[7:0]),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .id_mode(id_mode)
  );

  fcd_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT)) u_guard (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_op(cmd_op),
    .wr_addr(wr_addr), .wr_data(wr_data), .hv_ovr(hv_override),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_regions(req_regions), .locked(locked)
  );

  fcd_id_rom #(.ADDR_W(ADDR_W)) u_id (
    .clk(clk), .rst(rst), .id_mode(id_mode), .locked(locked),
    .rd_addr(rd_addr), .id_rd_data(id_rd_data)
  );
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        hv_override = 1'b0;
  logic [16:0] rd_addr = '0;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [16:0] req_addr;
  logic [15:0] req_data;
  logic [3:0]  req_regions;
  logic        id_mode;
  logic        locked;
  logic [7:0]  id_rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  typedef struct {
    logic [1:0]  op;
    logic [16:0] addr;
    logic [15:0] data;
    logic [3:0]  regions;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .hv_override(hv_override), .rd_addr(rd_addr),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_regions(req_regions), .id_mode(id_mode),
    .locked(locked), .id_rd_data(id_rd_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compare every request against the scoreboard
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected request op/addr", {13'd0, req_op, req_addr}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(req_op == e.op && req_addr == e.addr && req_data == e.data && req_regions == e.regions,
            e.tag, "request op/addr/data/regions",
            {req_op, req_regions, req_data[9:0], req_addr[15:0]},
            {e.op, e.regions, e.data[9:0], e.addr[15:0]});
      end
    end
  end

  task automatic expect_req(input logic [1:0] op, input logic [16:0] a,
                            input logic [15:0] d, input logic [3:0] rg, input string tag);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.regions = rg; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [16:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(17'h05555, 16'h00AA);
    wr(17'h02AAA, 16'h0055);
  endtask

  task automatic prog(input logic [16:0] a, input logic [15:0] d);
    unlock();
    wr(17'h05555, 16'h00A0);
    wr(a, d);
  endtask

  task automatic erase6(input logic [16:0] a, input logic [15:0] d);
    unlock();
    wr(17'h05555, 16'h0080);
    unlock();
    wr(a, d);
  endtask

  task automatic drained(input string tag);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, tag, "pending expected requests", sb.size(), 0);
  endtask

  task automatic rd(input logic [16:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(id_rd_data == exp, tag, "id read data", id_rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(req_valid == 0 && id_mode == 0 && id_rd_data == 0, "R1", "reset outputs",
        {req_valid, id_mode, id_rd_data}, 0);
    chk(locked == 0, "R1", "power-up lock", locked, 0);

    // R2: plain word program
    cur_tag = "R2";
    expect_req(2'd0, 17'h0A123, 16'hBEEF, 4'b1000, "R2");
    prog(17'h0A123, 16'hBEEF);
    drained("R2");

    // R3: upper data bits ignored in command codes
    cur_tag = "R3";
    expect_req(2'd0, 17'h04010, 16'h1234, 4'b0100, "R3");
    wr(17'h05555, 16'h12AA);
    wr(17'h02AAA, 16'hFF55);
    wr(17'h05555, 16'h77A0);
    wr(17'h04010, 16'h1234);
    drained("R3");

    // R4: mismatch returns to idle, offending write not reused
    cur_tag = "R4";
    wr(17'h05555, 16'h00AA);
    wr(17'h02AAA, 16'h0056);
    wr(17'h05555, 16'h00A0);
    wr(17'h0A000, 16'h0000);
    unlock();
    wr(17'h05555, 16'h0080);
    wr(17'h05555, 16'h00AA);
    wr(17'h02AAA, 16'h0054);
    wr(17'h05555, 16'h0010);
    drained("R4");
    expect_req(2'd0, 17'h08000, 16'h00C3, 4'b1000, "R4");
    prog(17'h08000, 16'h00C3);
    drained("R4");

    // R5: chip erase, unlocked
    cur_tag = "R5";
    expect_req(2'd1, 17'h05555, 16'h0010, 4'b1111, "R5");
    erase6(17'h05555, 16'h0010);
    drained("R5");

    // R6: sector erase extents
    cur_tag = "R6";
    expect_req(2'd2, 17'h03000, 16'h0030, 4'b0010, "R6");
    erase6(17'h03000, 16'h0030);
    expect_req(2'd2, 17'h05000, 16'h0030, 4'b0100, "R6");
    erase6(17'h05000, 16'h0030);
    expect_req(2'd2, 17'h1F000, 16'h0030, 4'b1001, "R6");
    erase6(17'h1F000, 16'h0030);
    drained("R6");

    // R12: writes ignored while busy
    cur_tag = "R12";
    expect_req(2'd0, 17'h0C000, 16'h5A5A, 4'b1000, "R12");
    unlock();
    busy = 1'b1;
    wr(17'h00000, 16'h0000);
    wr(17'h05555, 16'h0090);
    busy = 1'b0;
    chk(id_mode == 0, "R12", "id mode during busy", id_mode, 0);
    wr(17'h05555, 16'h00A0);
    wr(17'h0C000, 16'h5A5A);
    drained("R12");

    // R10 / R11: product-ID mode
    cur_tag = "R10";
    rd(17'h00000, 8'h00, "R11");
    unlock();
    wr(17'h05555, 16'h0090);
    chk(id_mode == 1, "R10", "id mode after entry", id_mode, 1);
    rd(17'h00000, 8'h1F, "R11");
    rd(17'h00001, 8'h82, "R11");
    rd(17'h00002, 8'h00, "R11");
    rd(17'h00003, 8'h00, "R11");
    wr(17'h01234, 16'h00F0);
    chk(id_mode == 0, "R10", "id mode after single-write exit", id_mode, 0);
    unlock();
    wr(17'h05555, 16'h0090);
    chk(id_mode == 1, "R10", "id mode re-entry", id_mode, 1);
    unlock();
    wr(17'h05555, 16'h00F0);
    chk(id_mode == 0, "R10", "id mode after three-write exit", id_mode, 0);
    drained("R10");

    // R7: lock enable, sticky across reset
    cur_tag = "R7";
    erase6(17'h05555, 16'h0040);
    chk(locked == 1, "R7", "lock set", locked, 1);
    unlock();
    wr(17'h05555, 16'h0090);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(locked == 1, "R7", "lock after reset", locked, 1);
    chk(id_mode == 0, "R1", "id mode cleared by reset", id_mode, 0);
    unlock();
    wr(17'h05555, 16'h0090);
    rd(17'h00002, 8'h01, "R11");
    wr(17'h00000, 16'h00F0);
    drained("R7");

    // R8: lock enforcement
    cur_tag = "R8";
    erase6(17'h05555, 16'h0010);
    prog(17'h01000, 16'h0000);
    drained("R8");
    expect_req(2'd0, 17'h02000, 16'h1111, 4'b0010, "R8");
    prog(17'h02000, 16'h1111);
    expect_req(2'd2, 17'h1F000, 16'h0030, 4'b1000, "R8");
    erase6(17'h1F000, 16'h0030);
    drained("R8");

    // R9: override lifts the lock
    cur_tag = "R9";
    hv_override = 1'b1;
    expect_req(2'd0, 17'h00100, 16'h2222, 4'b0001, "R9");
    prog(17'h00100, 16'h2222);
    expect_req(2'd1, 17'h05555, 16'h0010, 4'b1111, "R9");
    erase6(17'h05555, 16'h0010);
    expect_req(2'd2, 17'h00000, 16'h0030, 4'b1001, "R9");
    erase6(17'h00000, 16'h0030);
    drained("R9");
    hv_override = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog expired actual 1 expected 0", cur_tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule